// File: doc/BRIEF.md
# T1 Per-Channel Substitution Multiplexer

This block sits on the serial bit streams of a T1 interface, where each frame has 193 bit times: one framing bit and then 24 channels of eight bits each. Both directions run from one shared bit clock and one frame sync pulse. On the transmit path, any channel from the backplane can be swapped out. In idle mode the channel carries a fixed idle code. In loopback mode it carries the same channel's bits as they arrive on the receive line. On the receive path, any channel can be overwritten with an eight-bit code, with one code register for each channel. The framing bit always passes through unchanged.

Configuration arrives on a simple write port. The writes land in shadow registers. The working copy is reloaded only at the start of each frame, so no channel is ever partly substituted. Both outputs are registered and lag their inputs by exactly one clock.

Top module: `t1_chan_subst`

## Requirements
- R1: After reset, tx_out and rx_out are 0, every select bit, insert bit and code is 0, and the mode is idle. The outputs therefore copy their inputs.
- R2: A high fsync marks the current bit time as the framing bit (position 0). Without fsync, the position counts 0 to 192 and wraps to 0. Channel k (1..24) occupies positions 8k-7 to 8k. Each output bit appears one clock after the input bit it belongs to.
- R3: The framing bit is never substituted on either path. tx_out copies tx_in and rx_out copies rx_in for that bit time.
- R4: Transmit select bits are at addresses 0, 1 and 2. Channel k is bit (k-1) mod 8 of address (k-1) div 8, so CH1 is bit 0 of address 0 and CH24 is bit 7 of address 2.
- R5: When the mode bit is 0, a selected transmit channel carries the idle code 0x7F, most significant bit first.
- R6: When the mode bit is 1 (bit 0 of address 6), a selected transmit channel carries rx_in of the same bit time in place of tx_in.
- R7: An unselected transmit channel passes tx_in unchanged.
- R8: Receive insert bits are at addresses 3, 4 and 5, mapped the same way as in R4. The code for channel k is at address 7+k. A channel whose insert bit is set carries its code on rx_out, most significant bit first. A channel whose insert bit is clear passes rx_in.
- R9: A write takes effect starting at the next framing bit. The frame in progress keeps the settings it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock for both paths |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | High during the framing bit time |
| tx_in | input | 1 | Serial transmit data from the backplane |
| rx_in | input | 1 | Serial receive data from the line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| tx_out | output | 1 | Serial transmit data after substitution |
| rx_out | output | 1 | Serial receive data after insertion |

## Verification
A wrong bit position makes a substituted channel appear shifted in time. The bit order of the idle code or the inserted code would then be wrong within the first frame. A stale or early copy of the working registers shows up as a frame whose substituted channels do not match the settings that were in force at its framing bit. The bench writes registers in the middle of a frame so that this mismatch appears within two frames. A framing-bit leak is visible at position 0 of any frame once every channel is selected.

// File: rtl/t1_subst_pkg.sv
package t1_subst_pkg;

  // Zero-based channel index for a frame position (position 0 is framing).
  function automatic int unsigned chan_of(int unsigned pos, int unsigned cw);
    if (pos == 0) return 0;
    return (pos - 1) / cw;
  endfunction

  // Index of the code bit sent at a position, most significant bit first.
  function automatic int unsigned msb_idx(int unsigned pos, int unsigned cw);
    if (pos == 0) return cw - 1;
    return cw - 1 - ((pos - 1) % cw);
  endfunction

endpackage

// File: rtl/t1_frame_timer.sv
module t1_frame_timer #(
  parameter int NCH = 24,
  parameter int CW  = 8,
  localparam int FRAME_BITS = NCH * CW + 1,
  localparam int PW  = $clog2(FRAME_BITS),
  localparam int CHW = $clog2(NCH),
  localparam int BW  = $clog2(CW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fsync,
  output logic           framing,
  output logic [CHW-1:0] chan,
  output logic [BW-1:0]  bidx
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0] pos_q, pos_now;

  always_comb begin
    if (fsync || pos_q == LAST) pos_now = '0;
    else                        pos_now = pos_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= LAST;
    else        pos_q <= pos_now;
  end

  assign framing = (pos_now == '0);
  assign chan    = CHW'(t1_subst_pkg::chan_of(int'(pos_now), CW));
  assign bidx    = BW'(t1_subst_pkg::msb_idx(int'(pos_now), CW));

  // R2: the position register never leaves the frame range
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);

  // R2: two framing bits in a row only when a sync forces it
  p_no_double_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    framing |=> (!framing || fsync));

endmodule

// File: rtl/t1_chan_regs.sv
module t1_chan_regs #(
  parameter int NCH       = 24,
  parameter int CW        = 8,
  parameter int AW        = 5,
  parameter int SEL_BASE  = 0,
  parameter int INS_BASE  = 3,
  parameter int MODE_ADDR = 6,
  parameter int CODE_BASE = 8,
  localparam int NBANK = (NCH + CW - 1) / CW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    boundary,
  output logic [NCH-1:0]          tx_sel,
  output logic [NCH-1:0]          rx_ins,
  output logic                    loop_mode,
  output logic [NCH-1:0][CW-1:0]  codes
);
  logic [NBANK*CW-1:0]   sh_sel, sh_ins;
  logic                  sh_mode;
  logic [NCH-1:0][CW-1:0] sh_code;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_sel[g*CW +: CW] <= '0;
        sh_ins[g*CW +: CW] <= '0;
      end else if (wr_en) begin
        if (wr_addr == AW'(SEL_BASE + g)) sh_sel[g*CW +: CW] <= wr_data;
        if (wr_addr == AW'(INS_BASE + g)) sh_ins[g*CW +: CW] <= wr_data;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      sh_code[c] <= '0;
      else if (wr_en && wr_addr == AW'(CODE_BASE + c)) sh_code[c] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   sh_mode <= 1'b0;
    else if (wr_en && wr_addr == AW'(MODE_ADDR)) sh_mode <= wr_data[0];
  end

  // Working copy reloads only at the framing bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sel    <= '0;
      rx_ins    <= '0;
      loop_mode <= 1'b0;
      codes     <= '0;
    end else if (boundary) begin
      tx_sel    <= sh_sel[NCH-1:0];
      rx_ins    <= sh_ins[NCH-1:0];
      loop_mode <= sh_mode;
      codes     <= sh_code;
    end
  end

  // R9: working settings never change inside a frame
  p_hold_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(tx_sel) && $stable(rx_ins) && $stable(loop_mode)));
  p_hold_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(codes));

endmodule

// File: rtl/t1_slot_mux.sv
module t1_slot_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic framing,
  input  logic sel,
  input  logic alt_bit,
  input  logic in_bit,
  output logic out_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                out_bit <= 1'b0;
    else if (!framing && sel)  out_bit <= alt_bit;
    else                       out_bit <= in_bit;
  end

  // R3: the framing bit always passes through
  p_frame_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    framing |=> (out_bit == $past(in_bit)));

endmodule

// File: rtl/t1_chan_subst.sv
module t1_chan_subst #(
  parameter int NCH = 24,
  parameter int CW  = 8,
  parameter int AW  = 5,
  parameter logic [CW-1:0] IDLE_CODE = 8'h7F,
  localparam int CHW = $clog2(NCH),
  localparam int BW  = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          tx_in,
  input  logic          rx_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          tx_out,
  output logic          rx_out
);
  logic                   framing;
  logic [CHW-1:0]         chan;
  logic [BW-1:0]          bidx;
  logic [NCH-1:0]         tx_sel, rx_ins;
  logic                   loop_mode;
  logic [NCH-1:0][CW-1:0] codes;

  t1_frame_timer #(.NCH(NCH), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .framing(framing), .chan(chan), .bidx(bidx)
  );

  t1_chan_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .boundary(framing),
    .tx_sel(tx_sel), .rx_ins(rx_ins), .loop_mode(loop_mode), .codes(codes)
  );

  // Named events for the checks below
  logic tx_hit, rx_hit, tx_alt, rx_alt;
  assign tx_hit = tx_sel[chan];
  assign rx_hit = rx_ins[chan];
  assign tx_alt = loop_mode ? rx_in : IDLE_CODE[bidx];
  assign rx_alt = codes[chan][bidx];

  t1_slot_mux u_tx_mux (
    .clk(clk), .rst_n(rst_n), .framing(framing), .sel(tx_hit),
    .alt_bit(tx_alt), .in_bit(tx_in), .out_bit(tx_out)
  );

  t1_slot_mux u_rx_mux (
    .clk(clk), .rst_n(rst_n), .framing(framing), .sel(rx_hit),
    .alt_bit(rx_alt), .in_bit(rx_in), .out_bit(rx_out)
  );

  // R6: loopback channels carry the line bit
  p_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && tx_hit && !framing) |=> (tx_out == $past(rx_in)));

  // R7: unselected transmit channels pass through
  p_tx_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_hit && !framing) |=> (tx_out == $past(tx_in)));

  // R5: first bit of an idle channel is the code's top bit
  p_idle_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_mode && tx_hit && !framing && bidx == BW'(CW-1))
      |=> (tx_out == IDLE_CODE[CW-1]));

  // R8: uninserted receive channels pass through
  p_rx_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_hit && !framing) |=> (rx_out == $past(rx_in)));

endmodule

// File: tb/t1_chan_subst_test.sv
`timescale 1ns/1ps
module t1_chan_subst_test;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, tx_in = 1'b0, rx_in = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tx_out, rx_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  t1_chan_subst uut (.*);

  always #4 clk = ~clk;

  // Bench-side register model
  logic [7:0] m_sh_bank [6], m_ac_bank [6];
  logic [7:0] m_sh_code [24], m_ac_code [24];
  logic       m_sh_mode, m_ac_mode;
  logic [192:0] last_tx, last_rx;

  task automatic check(bit ok, string tag, logic [192:0] act, logic [192:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void m_write(logic [4:0] a, logic [7:0] d);
    if (a < 6)       m_sh_bank[a] = d;
    else if (a == 6) m_sh_mode = d[0];
    else if (a >= 8) m_sh_code[a - 8] = d;
  endfunction

  function automatic void m_load();
    for (int i = 0; i < 6; i++)  m_ac_bank[i] = m_sh_bank[i];
    for (int i = 0; i < 24; i++) m_ac_code[i] = m_sh_code[i];
    m_ac_mode = m_sh_mode;
  endfunction

  task automatic wr_reg(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    m_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Streams frames, predicts both outputs, compares frame by frame
  task automatic run_frames(int nf, string tag, bit sync_each,
                            bit mid_wr, int wpos, logic [4:0] wa, logic [7:0] wd);
    logic [192:0] etx, erx, atx, arx;
    int prevp = -1;
    for (int f = 0; f < nf; f++) begin
      for (int p = 0; p < 193; p++) begin
        @(negedge clk);
        if (prevp >= 0) begin
          atx[prevp] = tx_out; arx[prevp] = rx_out;
          if (prevp == 192) begin
            check(atx == etx, {tag, " tx"}, atx, etx);
            check(arx == erx, {tag, " rx"}, arx, erx);
            check(atx[0] == etx[0] && arx[0] == erx[0], "R3 framing bit", atx, etx);
            last_tx = atx; last_rx = arx;
          end
        end
        if (p == 0) m_load();
        tx_in = 1'($urandom); rx_in = 1'($urandom);
        fsync = (p == 0) && (f == 0 || sync_each);
        if (mid_wr && f == 0 && p == wpos) begin
          wr_en = 1'b1; wr_addr = wa; wr_data = wd; m_write(wa, wd);
        end else wr_en = 1'b0;
        if (p == 0) begin
          etx[0] = tx_in; erx[0] = rx_in;
        end else begin
          int c = (p - 1) / 8;
          int b = 7 - (p - 1) % 8;
          logic [7:0] idle = 8'h7F;
          if (m_ac_bank[c / 8][c % 8]) etx[p] = m_ac_mode ? rx_in : idle[b];
          else                         etx[p] = tx_in;
          erx[p] = m_ac_bank[3 + c / 8][c % 8] ? m_ac_code[c][b] : rx_in;
        end
        prevp = p;
      end
    end
    @(negedge clk);
    atx[192] = tx_out; arx[192] = rx_out;
    check(atx == etx, {tag, " tx"}, atx, etx);
    check(arx == erx, {tag, " rx"}, arx, erx);
    last_tx = atx; last_rx = arx;
    fsync = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++)  m_sh_bank[i] = '0;
    for (int i = 0; i < 24; i++) m_sh_code[i] = '0;
    m_sh_mode = 1'b0;
    m_load();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_out == 1'b0, "R1 tx_out reset", 193'(tx_out), 193'(0));
    check(rx_out == 1'b0, "R1 rx_out reset", 193'(rx_out), 193'(0));
    rst_n = 1'b1;
    run_frames(1, "R1/R7 passthrough", 1, 0, 0, 0, 0);
  endtask

  task automatic t_map();
    logic [7:0] first, lastc;
    wr_reg(0, 8'h01); wr_reg(2, 8'h80);
    run_frames(2, "R4 edge channels", 1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      first[7 - i] = last_tx[1 + i];
      lastc[7 - i] = last_tx[185 + i];
    end
    check(first == 8'h7F, "R4/R5 CH1 idle", 193'(first), 193'(8'h7F));
    check(lastc == 8'h7F, "R4/R5 CH24 idle", 193'(lastc), 193'(8'h7F));
  endtask

  task automatic t_idle_mix();
    wr_reg(0, 8'h5A); wr_reg(1, 8'hC3); wr_reg(2, 8'h0F);
    run_frames(2, "R5/R7 idle mix", 1, 0, 0, 0, 0);
  endtask

  task automatic t_loop();
    wr_reg(6, 8'h01);
    run_frames(2, "R6 loopback", 1, 0, 0, 0, 0);
    run_frames(3, "R2 free-running wrap", 0, 0, 0, 0, 0);
  endtask

  task automatic t_insert();
    for (int c = 0; c < 24; c++) wr_reg(5'(8 + c), 8'((c * 37 + 5) & 255));
    wr_reg(3, 8'hFF); wr_reg(4, 8'h00); wr_reg(5, 8'hA5);
    run_frames(2, "R8 code insertion", 1, 0, 0, 0, 0);
  endtask

  task automatic t_all_sel();
    wr_reg(0, 8'hFF); wr_reg(1, 8'hFF); wr_reg(2, 8'hFF);
    wr_reg(3, 8'hFF); wr_reg(4, 8'hFF); wr_reg(5, 8'hFF);
    run_frames(2, "R3 all selected", 1, 0, 0, 0, 0);
    wr_reg(6, 8'h00);
    run_frames(1, "R3/R5 all idle", 1, 0, 0, 0, 0);
  endtask

  task automatic t_midwrite();
    run_frames(2, "R9 mid-frame select", 1, 1, 60, 5'd1, 8'h00);
    run_frames(2, "R9 mid-frame mode", 1, 1, 100, 5'd6, 8'h01);
    run_frames(2, "R9 mid-frame code", 1, 1, 5, 5'd12, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_map();
    t_idle_mix();
    t_loop();
    t_insert();
    t_all_sel();
    t_midwrite();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule